// File: doc/BRIEF.md
# Single-Bus Accumulator Processor Sequencer

This block is a 16-bit accumulator processor whose registers exchange data over one shared internal bus. A subcycle generator divides time into a fetch pass and an execute pass of eight subcycles each (T0 to T7). Only one register transfer uses the bus in any subcycle. The program counter is incremented by the shared adder, which is fed through two input latches (X and Y), rather than by an incrementer of its own. The block contains PC, MAR, MBR, IR, the accumulator G, and the latches X and Y.

The block talks to a synchronous word-addressed memory through `mem_addr`, `mem_wdata`, `mem_rdata`, `mem_rd` and `mem_wr`. Read data appears on `mem_rdata` on the clock edge that ends the cycle in which `mem_rd` is high. A keyboard word enters through `kbd_data`, qualified by `kbd_valid`. The `halted` output reports a stopped machine. `trap_code` shows the code carried by the most recent software trap.

States and transitions of the sequencer:
- The states are the pairs (phase, subcycle). The phase is FETCH or EXEC; the subcycle is T0..T7.
- **Advance**: the subcycle steps from T(n) to T(n+1).
- **Wrap**: from T7, the subcycle returns to T0 and the phase toggles.
- **Hold**: the state stays where it is. This happens while halted, or at EXEC T5 when the instruction is a halt, or when it is a keyboard read with `kbd_valid` low.
- **Reset**: the state goes to FETCH T0.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word has its opcode in bits 15:12 and its operand address in bits 11:0. The opcodes are:
  - 0 halt
  - 1 add
  - 2 xor
  - 3 and
  - 4 or
  - 5 invert G
  - 6 load G
  - 7 store G
  - 8 call
  - 9 jump if G negative
  - 10 jump
  - 11 indirect jump
  - 12 trap
  - 13 rotate left
  - 14 keyboard to G
  - 15 idle
- R2: The fetch pass behaves as follows:
  - `mem_rd` is high only in FETCH T1, with `mem_addr` equal to the PC of the instruction.
  - PC becomes PC+1 at the end of FETCH T3.
  - The fetched word executes in the following EXEC pass.
  - A non-stalling instruction takes 16 cycles.
- R3: The add, xor, and, or and load instructions read memory at the operand address in EXEC T1. They then combine that word with G (or load it into G). Invert replaces G with ~G. Rotate left moves G left by one bit, and the old bit 15 enters bit 0. Invert, rotate, keyboard, halt and idle ignore the operand field.
- R4: Store raises `mem_wr` in EXEC T2, with `mem_addr` equal to the operand and `mem_wdata` equal to G.
- R5: Jump sets PC to the operand. Jump-if-negative does so only when G bit 15 is 1, and otherwise leaves PC unchanged. Indirect jump reads the operand address and sets PC to bits 11:0 of that word.
- R6: Call writes the incremented PC to the operand address in EXEC T2. It then sets PC to the operand plus one.
- R7: Trap writes the incremented PC to address 0 in EXEC T2. It sets PC to operand bits 3:0 and sets `trap_code` to operand bits 11:4.
- R8: Keyboard-to-G holds at EXEC T5 while `kbd_valid` is 0. It loads `kbd_data` into G in the first cycle in which `kbd_valid` is 1.
- R9: Halt sets `halted` at the end of EXEC T5. The sequencer then stays frozen, with no memory strobe, until reset. Idle changes nothing.
- R10: A synchronous reset clears PC, G, `trap_code`, `halted` and the sequencer. The first strobe after reset is a fetch read of address 0.
- R11: `mem_rd` and `mem_wr` are never high together. An EXEC read occurs only for add, xor, and, or, load and indirect jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Word address (MAR) |
| mem_wdata | output | 16 | Write data (MBR) |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| kbd_data | input | 16 | Keyboard word |
| kbd_valid | input | 1 | Keyboard word is available |
| halted | output | 1 | Machine stopped by halt |
| trap_code | output | 8 | Code of the latest software trap |

## Verification
The hardest situations to reach from the ports are a keyboard stall and a trap whose return address is correct. Both sit deep in a program and depend on every earlier instruction computing the right PC. The bench therefore loads a single program that threads through every opcode. On the way it takes one conditional jump and declines another, calls into a region that waits on the keyboard, and jumps indirectly to a trap. The trap vectors to a final halt. The keyboard flag is held low until the reference model has counted several stalled cycles at EXEC T5. A second reset then fetches the trap-written word at address 0, which decodes as a halt.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int OPC_W  = 4;
    localparam int CODE_W = 8;
    localparam int VEC_W  = 4;
    localparam int SUB_W  = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_HALT  = 4'h0, OPC_ADD  = 4'h1, OPC_XOR  = 4'h2, OPC_AND  = 4'h3,
        OPC_OR    = 4'h4, OPC_INV  = 4'h5, OPC_LOAD = 4'h6, OPC_STORE = 4'h7,
        OPC_CALL  = 4'h8, OPC_JNEG = 4'h9, OPC_JUMP = 4'hA, OPC_JIND = 4'hB,
        OPC_TRAP  = 4'hC, OPC_ROTL = 4'hD, OPC_KEYIN = 4'hE, OPC_IDLE = 4'hF
    } opcode_e;

    typedef enum logic [SUB_W-1:0] {T0, T1, T2, T3, T4, T5, T6, T7} sub_e;
    typedef enum logic {PH_FETCH, PH_EXEC} phase_e;
    typedef enum logic [1:0] {ALU_ADD, ALU_XOR, ALU_AND, ALU_OR} alu_op_e;
endpackage

// File: rtl/acc_cpu_subcycle.sv
module acc_cpu_subcycle
    import acc_cpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hold,
    output phase_e phase,
    output sub_e   sub
);
    phase_e phase_q, phase_d;
    sub_e   sub_q, sub_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
            sub_q   <= T0;
        end else begin
            phase_q <= phase_d;
            sub_q   <= sub_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        sub_d   = sub_q;
        if (!hold) begin
            unique case (sub_q)
                T7: begin
                    sub_d   = T0;
                    phase_d = (phase_q == PH_FETCH) ? PH_EXEC : PH_FETCH;
                end
                default: sub_d = sub_e'(sub_q + 3'd1);
            endcase
        end
    end

    assign phase = phase_q;
    assign sub   = sub_q;

    // R2: wrap from T7 toggles the phase
    p_wrap_toggles_r2: assert property (@(posedge clk) disable iff (rst)
        (sub_q == T7 && !hold) |=> (sub_q == T0 && phase_q != $past(phase_q)));

    // R9: a held sequencer does not move
    p_hold_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(sub_q) && $stable(phase_q)));
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_XOR: y = a ^ b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [WORD_W-1:0] kbd_data,
    input  logic              kbd_valid,
    output logic              halted,
    output logic [CODE_W-1:0] trap_code
);
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    phase_e phase;
    sub_e   sub;
    logic   hold;

    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [WORD_W-1:0] mbr_q, ir_q, g_q, x_q, y_q;
    logic              halted_q;
    logic [CODE_W-1:0] code_q;

    logic [WORD_W-1:0] bus, alu_y;
    alu_op_e           alu_sel;
    logic ld_mar, ld_x, ld_y, ld_pc, ld_ir, ld_mbr, ld_g, ld_code, set_halt, rd, wr;

    opcode_e           opc;
    logic [ADDR_W-1:0] oper;
    logic              is_rd, is_wr, is_alu;

    assign opc    = opcode_e'(ir_q[WORD_W-1 -: OPC_W]);
    assign oper   = ir_q[ADDR_W-1:0];
    assign is_alu = opc inside {OPC_ADD, OPC_XOR, OPC_AND, OPC_OR};
    assign is_rd  = is_alu || opc == OPC_LOAD || opc == OPC_JIND;
    assign is_wr  = opc inside {OPC_STORE, OPC_CALL, OPC_TRAP};

    assign hold = halted_q ||
                  (phase == PH_EXEC && sub == T5 &&
                   (opc == OPC_HALT || (opc == OPC_KEYIN && !kbd_valid)));

    acc_cpu_subcycle u_seq (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold),
        .phase (phase),
        .sub   (sub)
    );

    acc_cpu_alu #(.W(WORD_W)) u_alu (
        .a  (x_q),
        .b  (y_q),
        .op (alu_sel),
        .y  (alu_y)
    );

    // Output process: one bus transfer per subcycle
    always_comb begin
        bus = '0;
        alu_sel = ALU_ADD;
        {ld_mar, ld_x, ld_y, ld_pc, ld_ir, ld_mbr, ld_g, ld_code, set_halt, rd, wr} = '0;
        if (phase == PH_FETCH) begin
            unique case (sub)
                T0: begin bus = WORD_W'(pc_q); ld_mar = 1'b1; ld_x = 1'b1; end
                T1: begin bus = ONE; ld_y = 1'b1; rd = 1'b1; end
                T2: begin bus = mem_rdata; ld_mbr = 1'b1; end
                T3: begin bus = alu_y; ld_pc = 1'b1; end
                T5: begin bus = mbr_q; ld_ir = 1'b1; end
                default: ;
            endcase
        end else begin
            unique case (sub)
                T0: begin
                    if (is_rd || opc == OPC_STORE || opc == OPC_CALL) begin
                        bus = WORD_W'(oper); ld_mar = 1'b1;
                    end else if (opc == OPC_TRAP) begin
                        bus = '0; ld_mar = 1'b1;
                    end
                end
                T1: begin
                    if (is_rd) rd = 1'b1;
                    else if (opc == OPC_STORE) begin bus = g_q; ld_mbr = 1'b1; end
                    else if (opc == OPC_CALL || opc == OPC_TRAP) begin
                        bus = WORD_W'(pc_q); ld_mbr = 1'b1;
                    end
                end
                T2: begin
                    if (is_rd) begin bus = mem_rdata; ld_mbr = 1'b1; end
                    else if (is_wr) wr = 1'b1;
                end
                T3: begin
                    if (is_alu) begin bus = g_q; ld_x = 1'b1; end
                    else if (opc == OPC_CALL) begin bus = WORD_W'(oper); ld_x = 1'b1; end
                end
                T4: begin
                    if (is_alu) begin bus = mbr_q; ld_y = 1'b1; end
                    else if (opc == OPC_CALL) begin bus = ONE; ld_y = 1'b1; end
                end
                T5: begin
                    unique case (opc)
                        OPC_ADD:   begin alu_sel = ALU_ADD; bus = alu_y; ld_g = 1'b1; end
                        OPC_XOR:   begin alu_sel = ALU_XOR; bus = alu_y; ld_g = 1'b1; end
                        OPC_AND:   begin alu_sel = ALU_AND; bus = alu_y; ld_g = 1'b1; end
                        OPC_OR:    begin alu_sel = ALU_OR;  bus = alu_y; ld_g = 1'b1; end
                        OPC_LOAD:  begin bus = mbr_q; ld_g = 1'b1; end
                        OPC_INV:   begin bus = ~g_q; ld_g = 1'b1; end
                        OPC_ROTL:  begin bus = {g_q[WORD_W-2:0], g_q[WORD_W-1]}; ld_g = 1'b1; end
                        OPC_KEYIN: begin bus = kbd_data; ld_g = kbd_valid; end
                        OPC_JUMP:  begin bus = WORD_W'(oper); ld_pc = 1'b1; end
                        OPC_JNEG:  begin bus = WORD_W'(oper); ld_pc = g_q[WORD_W-1]; end
                        OPC_JIND:  begin bus = mbr_q; ld_pc = 1'b1; end
                        OPC_CALL:  begin bus = alu_y; ld_pc = 1'b1; end
                        OPC_TRAP:  begin
                            bus = WORD_W'(ir_q[VEC_W-1:0]); ld_pc = 1'b1; ld_code = 1'b1;
                        end
                        OPC_HALT:  set_halt = 1'b1;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0; mar_q <= '0; mbr_q <= '0; ir_q <= '0;
            g_q <= '0; x_q <= '0; y_q <= '0; halted_q <= 1'b0; code_q <= '0;
        end else begin
            if (ld_mar)   mar_q    <= bus[ADDR_W-1:0];
            if (ld_x)     x_q      <= bus;
            if (ld_y)     y_q      <= bus;
            if (ld_pc)    pc_q     <= bus[ADDR_W-1:0];
            if (ld_ir)    ir_q     <= bus;
            if (ld_mbr)   mbr_q    <= bus;
            if (ld_g)     g_q      <= bus;
            if (ld_code)  code_q   <= ir_q[ADDR_W-1 -: CODE_W];
            if (set_halt) halted_q <= 1'b1;
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign mem_rd    = rd && !halted_q;
    assign mem_wr    = wr && !halted_q;
    assign halted    = halted_q;
    assign trap_code = code_q;

    // R11: strobes exclusive
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R2: fetch reads only in T1, at the instruction address
    p_fetch_read_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH && mem_rd) |-> (sub == T1 && mem_addr == pc_q));

    // R2: PC steps by one after fetch T3
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH && sub == T3) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

    // R9: halt is sticky and silences memory
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> (halted_q && !mem_rd && !mem_wr));

    // R5: untaken negative jump leaves PC alone
    p_jneg_untaken_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && sub == T5 && opc == OPC_JNEG && !g_q[WORD_W-1])
        |=> $stable(pc_q));

    // R7: trap exposes its code field
    p_trap_code_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && sub == T5 && opc == OPC_TRAP)
        |=> (trap_code == $past(ir_q[ADDR_W-1 -: CODE_W])));
endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd, mem_wr;
    logic [15:0] kbd_data = 16'hA5A5;
    logic        kbd_valid = 1'b0;
    logic        halted;
    logic [7:0]  trap_code;

    always #5 clk = ~clk;

    acc_cpu uut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .kbd_data(kbd_data), .kbd_valid(kbd_valid), .halted(halted),
        .trap_code(trap_code)
    );

    int n_checks = 0;
    int n_err = 0;
    logic [15:0] mem     [0:255];
    logic [15:0] ref_mem [0:255];

    // Synchronous memory device
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] = mem_wdata;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic put(input int adr, input logic [15:0] w);
        mem[adr] = w;
        ref_mem[adr] = w;
    endtask

    // Reference model: state mirrors design after each edge
    bit          m_ok = 0;
    int          m_ph, m_t, kbd_wait = 0;
    logic [11:0] m_pc, m_fa;
    logic [15:0] m_g, m_ir;
    logic [7:0]  m_code;
    bit          m_halt;

    always @(negedge clk) begin
        logic [3:0]  op;
        logic [11:0] a;
        bit er, ew, rdop, wrop, adv;
        op = m_ir[15:12];
        a  = m_ir[11:0];
        rdop = (op inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd11});
        wrop = (op inside {4'd7, 4'd8, 4'd12});
        if (m_ok) begin
            er = !m_halt && m_t == 1 && (m_ph == 0 || rdop);
            ew = !m_halt && m_ph == 1 && m_t == 2 && wrop;
            check("R2/R11 read strobe", mem_rd, er);
            check("R4/R11 write strobe", mem_wr, ew);
            if (er) check("R2/R3 read address", mem_addr, (m_ph == 0) ? m_fa : a);
            if (ew) begin
                check("R4/R6/R7 write address", mem_addr, (op == 4'd12) ? 12'd0 : a);
                check("R4/R6/R7 write data", mem_wdata, (op == 4'd7) ? m_g : {4'd0, m_pc});
            end
            check("R9 halted", halted, m_halt);
            check("R7 trap code", trap_code, m_code);
        end
        if (rst) begin
            m_ok = 1; m_ph = 0; m_t = 0; m_pc = 0; m_fa = 0; m_g = 0;
            m_ir = 0; m_halt = 0; m_code = 0;
        end else if (m_ok && !m_halt) begin
            adv = 1;
            if (m_ph == 0) begin
                if (m_t == 0) m_fa = m_pc;
                if (m_t == 3) m_pc = m_pc + 12'd1;
                if (m_t == 5) m_ir = ref_mem[m_fa[7:0]];
            end else if (m_t == 2 && wrop) begin
                if (op == 4'd7) ref_mem[a[7:0]] = m_g;
                else if (op == 4'd8) ref_mem[a[7:0]] = {4'd0, m_pc};
                else ref_mem[0] = {4'd0, m_pc};
            end else if (m_t == 5) begin
                case (op)
                    4'd0:  begin m_halt = 1; adv = 0; end
                    4'd1:  m_g = m_g + ref_mem[a[7:0]];
                    4'd2:  m_g = m_g ^ ref_mem[a[7:0]];
                    4'd3:  m_g = m_g & ref_mem[a[7:0]];
                    4'd4:  m_g = m_g | ref_mem[a[7:0]];
                    4'd5:  m_g = ~m_g;
                    4'd6:  m_g = ref_mem[a[7:0]];
                    4'd8:  m_pc = a + 12'd1;
                    4'd9:  if (m_g[15]) m_pc = a;
                    4'd10: m_pc = a;
                    4'd11: m_pc = ref_mem[a[7:0]][11:0];
                    4'd12: begin m_pc = {8'd0, m_ir[3:0]}; m_code = m_ir[11:4]; end
                    4'd13: m_g = {m_g[14:0], m_g[15]};
                    4'd14: if (kbd_valid) m_g = kbd_data;
                           else begin kbd_wait++; adv = 0; end
                    default: ;
                endcase
            end
            if (adv) begin
                if (m_t == 7) begin m_t = 0; m_ph = 1 - m_ph; end
                else m_t = m_t + 1;
            end
        end
    end

    // Keyboard device: becomes ready after several stalled cycles
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (kbd_wait >= 4) kbd_valid = 1'b1;
        end
    end

    initial begin
        #1000000;
        n_err++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) put(i, 16'h0000);
        put(8'h00, 16'h6040); put(8'h01, 16'h1041); put(8'h02, 16'h7050);
        put(8'h03, 16'h2042); put(8'h04, 16'h7051); put(8'h05, 16'h3043);
        put(8'h06, 16'h4044); put(8'h07, 16'h7052); put(8'h08, 16'hD000);
        put(8'h09, 16'h7053); put(8'h0A, 16'h9020); put(8'h0B, 16'h5123);
        put(8'h0C, 16'h900E); put(8'h0D, 16'h0000); put(8'h0E, 16'h8030);
        put(8'h0F, 16'hA070);
        put(8'h31, 16'hE000); put(8'h32, 16'h7054); put(8'h33, 16'hB045);
        put(8'h60, 16'hCABF); put(8'h70, 16'hF000); put(8'h71, 16'h0000);
        put(8'h40, 16'h1234); put(8'h41, 16'h0F0F); put(8'h42, 16'hFFFF);
        put(8'h43, 16'h0FF0); put(8'h44, 16'h8001); put(8'h45, 16'hF060);

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R10 halted after reset", halted, 1'b0);
        check("R10 trap code after reset", trap_code, 8'h00);
        check("R10 no strobe at fetch T0", {mem_rd, mem_wr}, 2'b00);
        @(negedge clk);
        check("R10 first fetch reads address 0", {mem_rd, mem_addr}, {1'b1, 12'h000});

        for (int i = 0; i < 4000 && !halted; i++) @(negedge clk);
        check("R9 program reaches halt", halted, 1'b1);
        repeat (10) @(negedge clk);
        check("R9 stays halted", halted, 1'b1);
        check("R3 load+add result", mem[8'h50], 16'h2143);
        check("R3 xor result", mem[8'h51], 16'hDEBC);
        check("R3 and+or result", mem[8'h52], 16'h8EB1);
        check("R3 rotate result", mem[8'h53], 16'h1D63);
        check("R8 keyboard word stored", mem[8'h54], 16'hA5A5);
        check("R8 keyboard stall observed", kbd_wait >= 4, 1'b1);
        check("R6 call return address", mem[8'h30], 16'h000F);
        check("R7 trap return address", mem[8'h00], 16'h0061);
        check("R7 trap code field", trap_code, 8'hAB);
        check("R5 skipped halt not reached early", mem[8'h20], 16'h0000);

        @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R10 reset clears halted", halted, 1'b0);
        check("R10 reset clears trap code", trap_code, 8'h00);
        for (int i = 0; i < 100 && !halted; i++) @(negedge clk);
        check("R1 word 0x0061 decodes as halt", halted, 1'b1);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule